// File: doc/BRIEF.md
# Lockable Secure Configuration Write Guard

This block sits beside the system-control register path of a processor and judges every decoded register access in the cycle it is presented. An access is described by its read/write flag and its four encoding fields (first opcode, primary register number, secondary register number, second opcode). The block also sees the current processor mode, the security state bit, a lock input driven by the surrounding chip, and two bits that say whether each tightly-coupled-memory (TCM) region register may be reached from the non-secure side. For every valid access it either raises an undefined-instruction trap or grants a commit. It also holds the protected registers as a small register file, so a blocked write visibly leaves the stored value untouched.

Protected registers, apart from the two TCM region registers, may be accessed only from monitor mode or from a privileged mode in the secure state. When the lock is in force, writes to every protected encoding trap, while reads still pass. The two TCM region registers are locked only when their own non-secure access bit is clear. The lock input is registered every cycle, but it only becomes the effective lock on a one-cycle pipeline flush pulse. A two-bit state machine holds both the registered lock request and the effective lock. Its states are OPEN (not locked, no request), ARMED (request seen, not yet in force), SEALED (locked, request still high) and RELEASING (locked, request dropped). Its transitions are: arm (OPEN to ARMED on lock high), disarm (ARMED to OPEN on lock low without flush), seal (ARMED to SEALED on flush with lock high), seal-and-drop (ARMED to RELEASING on flush with lock low), drop (SEALED to RELEASING on lock low), rearm (RELEASING to SEALED on lock high without flush), unlock (RELEASING to OPEN on flush with lock low) and unlock-rearm (RELEASING to ARMED on flush with lock high).

Top module: `scg_guard`

## Requirements
- R1: After reset the effective lock is off and every stored word is 0. A write to a protected encoding from mode 10011 with the security bit 0 then commits, and a later read returns the written data.
- R2: While the effective lock is on, a valid write to any protected non-TCM encoding asserts trap, deasserts commit and leaves the stored word unchanged. The protected non-TCM encodings as (opc1,CRn,CRm,opc2) are (0,1,0,0), (0,2,0,0), (0,2,0,2), (0,3,0,0), (0,9,1,2), (0,9,1,3), (0,10,2,0), (0,10,2,1), (0,12,0,0), (0,12,0,1), (0,13,0,0), (0,15,2,4), (3,15,8,x), (3,15,12,x), (5,15,4..7,2), (0,15,9,0), (0,15,12,4..7), (0,15,14,0) and (x,15,13,x).
- R3: A read that commits on a protected encoding returns the stored word on rd_data in the same cycle, whether or not the lock is on. Every other cycle drives rd_data to 0.
- R4: For protected non-TCM encodings, a read or write commits only from monitor mode (10110) or from a mode other than user (10000) with the security bit 0. Any other access traps, whatever the lock is.
- R5: The data TCM region register (0,9,1,0) and the instruction TCM region register (0,9,1,1) have no mode restriction. Under the lock, a write to either traps only when its own non-secure access input (dtcm_ns_ok or itcm_ns_ok) is 0.
- R6: lock_req is registered at every clock edge. The effective lock changes only at an edge where flush_pulse is 1, and it then takes the value registered at the previous edge. A flush in the same cycle that lock_req first rises therefore does not lock.
- R7: An encoding outside the protected list never traps, always commits when valid, and returns 0 on rd_data.
- R8: When acc_valid is 0, trap and commit are 0 and no stored word changes.
- R9: All opc2 values of (3,15,8,x) share one stored word, all opc2 values of (3,15,12,x) share one, and all validation encodings (0,15,9,0), (0,15,12,4..7), (0,15,14,0) and (x,15,13,x) share one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_opc1 | input | 3 | First opcode field |
| acc_crn | input | 4 | Primary register number |
| acc_crm | input | 4 | Secondary register number |
| acc_opc2 | input | 3 | Second opcode field |
| acc_wdata | input | 32 | Write data |
| cpu_mode | input | 5 | Processor mode (10000 user, 10110 monitor) |
| ns_state | input | 1 | Security state bit, 1 = non-secure |
| lock_req | input | 1 | Lock request from the chip |
| flush_pulse | input | 1 | One-cycle pipeline flush indication |
| dtcm_ns_ok | input | 1 | Data TCM region register non-secure access bit |
| itcm_ns_ok | input | 1 | Instruction TCM region register non-secure access bit |
| trap | output | 1 | Undefined-instruction trap for this access |
| commit | output | 1 | Access may commit |
| rd_data | output | 32 | Read data of a committed protected read |

## Verification
The bench goes after the lock timing first: a flush in the very cycle the request rises must not lock. A design that fed the raw input straight to the effective lock would trap the next write too early. The TCM region registers are driven from user, non-secure mode with each access bit in both states. A design that applied the privilege rule to them would trap accesses that should pass, and one that ignored the access bits would let locked writes through. The wildcard and validation groups are written through one encoding and read back through another, which exposes decoders that miss an opc2 value or fail to alias the storage. Random traffic mixes modes, security states, lock toggles and encodings outside the list, so that any leak of the lock onto ordinary registers shows up as a trap.

// File: rtl/scg_pkg.sv
package scg_pkg;
    localparam int DATA_W  = 32;
    localparam int MODE_W  = 5;
    localparam logic [MODE_W-1:0] MODE_USER    = 5'b10000;
    localparam logic [MODE_W-1:0] MODE_MONITOR = 5'b10110;

    localparam int SL_SCTL  = 0;
    localparam int SL_TTB0  = 1;
    localparam int SL_TTBC  = 2;
    localparam int SL_DACR  = 3;
    localparam int SL_DNSAC = 4;
    localparam int SL_INSAC = 5;
    localparam int SL_DRGN  = 6;
    localparam int SL_IRGN  = 7;
    localparam int SL_PRMP  = 8;
    localparam int SL_NRMP  = 9;
    localparam int SL_SVEC  = 10;
    localparam int SL_MVEC  = 11;
    localparam int SL_FCSE  = 12;
    localparam int SL_PPRM  = 13;
    localparam int SL_ICMV  = 14;
    localparam int SL_DCMV  = 15;
    localparam int SL_TLBI  = 16;
    localparam int SL_TLBV  = 17;
    localparam int SL_TLBP  = 18;
    localparam int SL_TLBA  = 19;
    localparam int SL_VALD  = 20;
    localparam int SLOT_N   = 21;
    localparam int SLOT_W   = $clog2(SLOT_N);

    typedef enum logic [1:0] {
        ST_OPEN      = 2'b00,
        ST_ARMED     = 2'b01,
        ST_SEALED    = 2'b11,
        ST_RELEASING = 2'b10
    } lock_state_e;
endpackage

// File: rtl/scg_decode.sv
module scg_decode
    import scg_pkg::*;
(
    input  logic [2:0]        opc1,
    input  logic [3:0]        crn,
    input  logic [3:0]        crm,
    input  logic [2:0]        opc2,
    output logic              hit,
    output logic [SLOT_W-1:0] slot,
    output logic              tcm_d,
    output logic              tcm_i
);
    logic [13:0] key;
    int          idx;

    assign key = {opc1, crn, crm, opc2};

    always_comb begin
        idx = -1;
        casez (key)
            {3'd0, 4'd1,  4'd0,  3'd0}: idx = SL_SCTL;
            {3'd0, 4'd2,  4'd0,  3'd0}: idx = SL_TTB0;
            {3'd0, 4'd2,  4'd0,  3'd2}: idx = SL_TTBC;
            {3'd0, 4'd3,  4'd0,  3'd0}: idx = SL_DACR;
            {3'd0, 4'd9,  4'd1,  3'd2}: idx = SL_DNSAC;
            {3'd0, 4'd9,  4'd1,  3'd3}: idx = SL_INSAC;
            {3'd0, 4'd9,  4'd1,  3'd0}: idx = SL_DRGN;
            {3'd0, 4'd9,  4'd1,  3'd1}: idx = SL_IRGN;
            {3'd0, 4'd10, 4'd2,  3'd0}: idx = SL_PRMP;
            {3'd0, 4'd10, 4'd2,  3'd1}: idx = SL_NRMP;
            {3'd0, 4'd12, 4'd0,  3'd0}: idx = SL_SVEC;
            {3'd0, 4'd12, 4'd0,  3'd1}: idx = SL_MVEC;
            {3'd0, 4'd13, 4'd0,  3'd0}: idx = SL_FCSE;
            {3'd0, 4'd15, 4'd2,  3'd4}: idx = SL_PPRM;
            14'b011_1111_1000_???:      idx = SL_ICMV;
            14'b011_1111_1100_???:      idx = SL_DCMV;
            {3'd5, 4'd15, 4'd4,  3'd2}: idx = SL_TLBI;
            {3'd5, 4'd15, 4'd5,  3'd2}: idx = SL_TLBV;
            {3'd5, 4'd15, 4'd6,  3'd2}: idx = SL_TLBP;
            {3'd5, 4'd15, 4'd7,  3'd2}: idx = SL_TLBA;
            {3'd0, 4'd15, 4'd9,  3'd0}: idx = SL_VALD;
            14'b000_1111_1100_1??:      idx = SL_VALD;
            {3'd0, 4'd15, 4'd14, 3'd0}: idx = SL_VALD;
            14'b???_1111_1101_???:      idx = SL_VALD;
            default:                    idx = -1;
        endcase
    end

    assign hit   = (idx >= 0);
    assign slot  = hit ? idx[SLOT_W-1:0] : '0;
    assign tcm_d = (idx == SL_DRGN);
    assign tcm_i = (idx == SL_IRGN);
endmodule

// File: rtl/scg_lock_fsm.sv
module scg_lock_fsm
    import scg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lock_req,
    input  logic flush_pulse,
    output logic lock_eff,
    output logic lock_pend
);
    lock_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN:
                state_d = lock_req ? ST_ARMED : ST_OPEN;
            ST_ARMED:
                if (flush_pulse) state_d = lock_req ? ST_SEALED : ST_RELEASING;
                else             state_d = lock_req ? ST_ARMED  : ST_OPEN;
            ST_SEALED:
                state_d = lock_req ? ST_SEALED : ST_RELEASING;
            ST_RELEASING:
                if (flush_pulse) state_d = lock_req ? ST_ARMED  : ST_OPEN;
                else             state_d = lock_req ? ST_SEALED : ST_RELEASING;
            default:
                state_d = ST_OPEN;
        endcase
    end

    always_comb begin
        lock_eff  = 1'b0;
        lock_pend = 1'b0;
        unique case (state_q)
            ST_OPEN:      begin lock_eff = 1'b0; lock_pend = 1'b0; end
            ST_ARMED:     begin lock_eff = 1'b0; lock_pend = 1'b1; end
            ST_SEALED:    begin lock_eff = 1'b1; lock_pend = 1'b1; end
            ST_RELEASING: begin lock_eff = 1'b1; lock_pend = 1'b0; end
            default:      begin lock_eff = 1'b0; lock_pend = 1'b0; end
        endcase
    end
endmodule

// File: rtl/scg_policy.sv
module scg_policy
    import scg_pkg::*;
(
    input  logic              valid,
    input  logic              write,
    input  logic              hit,
    input  logic              tcm_d,
    input  logic              tcm_i,
    input  logic [MODE_W-1:0] mode,
    input  logic              ns,
    input  logic              lock_eff,
    input  logic              dtcm_ok,
    input  logic              itcm_ok,
    output logic              trap,
    output logic              commit
);
    logic priv_ok, is_tcm, tcm_open, mode_fail, lock_fail;

    always_comb begin
        priv_ok   = (mode == MODE_MONITOR) || ((mode != MODE_USER) && !ns);
        is_tcm    = tcm_d | tcm_i;
        tcm_open  = tcm_d ? dtcm_ok : itcm_ok;
        mode_fail = !is_tcm && !priv_ok;
        lock_fail = write && lock_eff && (is_tcm ? !tcm_open : 1'b1);
        trap      = valid && hit && (mode_fail || lock_fail);
        commit    = valid && !trap;
    end
endmodule

// File: rtl/scg_regfile.sv
module scg_regfile
    import scg_pkg::*;
#(
    parameter int N = SLOT_N,
    parameter int W = DATA_W,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] word_q [N];

    for (genvar g = 0; g < N; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      word_q[g] <= '0;
            else if (we && (addr == AW'(g))) word_q[g] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N; i++)
            if (addr == AW'(i)) rdata = word_q[i];
    end
endmodule

// File: rtl/scg_guard.sv
module scg_guard
    import scg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [2:0]        acc_opc1,
    input  logic [3:0]        acc_crn,
    input  logic [3:0]        acc_crm,
    input  logic [2:0]        acc_opc2,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [MODE_W-1:0] cpu_mode,
    input  logic              ns_state,
    input  logic              lock_req,
    input  logic              flush_pulse,
    input  logic              dtcm_ns_ok,
    input  logic              itcm_ns_ok,
    output logic              trap,
    output logic              commit,
    output logic [DATA_W-1:0] rd_data
);
    logic              dec_hit, dec_tcm_d, dec_tcm_i;
    logic [SLOT_W-1:0] dec_slot;
    logic              lock_eff, lock_pend;
    logic [DATA_W-1:0] word_rd;
    logic              rf_we;

    scg_decode u_dec (
        .opc1 (acc_opc1), .crn (acc_crn), .crm (acc_crm), .opc2 (acc_opc2),
        .hit  (dec_hit),  .slot (dec_slot),
        .tcm_d(dec_tcm_d), .tcm_i(dec_tcm_i)
    );

    scg_lock_fsm u_lock (
        .clk (clk), .rst_n (rst_n),
        .lock_req (lock_req), .flush_pulse (flush_pulse),
        .lock_eff (lock_eff), .lock_pend (lock_pend)
    );

    scg_policy u_pol (
        .valid (acc_valid), .write (acc_write), .hit (dec_hit),
        .tcm_d (dec_tcm_d), .tcm_i (dec_tcm_i),
        .mode (cpu_mode), .ns (ns_state), .lock_eff (lock_eff),
        .dtcm_ok (dtcm_ns_ok), .itcm_ok (itcm_ns_ok),
        .trap (trap), .commit (commit)
    );

    assign rf_we = commit && acc_write && dec_hit;

    scg_regfile #(.N(SLOT_N), .W(DATA_W)) u_rf (
        .clk (clk), .rst_n (rst_n), .we (rf_we),
        .addr (dec_slot), .wdata (acc_wdata), .rdata (word_rd)
    );

    assign rd_data = (commit && !acc_write && dec_hit) ? word_rd : '0;
endmodule

// File: rtl/scg_guard_chk.sv
module scg_guard_chk
    import scg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [MODE_W-1:0] cpu_mode,
    input logic              flush_pulse,
    input logic              dec_hit,
    input logic              dec_tcm_d,
    input logic              dec_tcm_i,
    input logic              lock_eff,
    input logic              lock_pend,
    input logic              trap,
    input logic              commit,
    input logic [DATA_W-1:0] rd_data
);
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> (!trap && !commit));

    a_r1_trap_commit_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap && commit));

    a_r2_sealed_write_traps: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && dec_hit && !dec_tcm_d && !dec_tcm_i && lock_eff)
        |-> trap);

    a_r4_user_traps: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && dec_hit && !dec_tcm_d && !dec_tcm_i && cpu_mode == MODE_USER)
        |-> trap);

    a_r6_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_pulse |=> $stable(lock_eff));

    a_r6_lock_takes_pend: assert property (@(posedge clk) disable iff (!rst_n)
        flush_pulse |=> (lock_eff == $past(lock_pend)));

    a_r7_unprotected_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !dec_hit) |-> (commit && rd_data == '0));

    a_r3_quiet_rdata: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit || acc_write) |-> (rd_data == '0));
endmodule

bind scg_guard scg_guard_chk u_chk (
    .clk (clk), .rst_n (rst_n), .acc_valid (acc_valid), .acc_write (acc_write),
    .cpu_mode (cpu_mode), .flush_pulse (flush_pulse), .dec_hit (dec_hit),
    .dec_tcm_d (dec_tcm_d), .dec_tcm_i (dec_tcm_i), .lock_eff (lock_eff),
    .lock_pend (lock_pend), .trap (trap), .commit (commit), .rd_data (rd_data)
);

// File: tb/tb_scg_guard.sv
module tb_scg_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 0, acc_write = 0;
    logic [2:0]  acc_opc1 = 0, acc_opc2 = 0;
    logic [3:0]  acc_crn = 0, acc_crm = 0;
    logic [31:0] acc_wdata = 0;
    logic [4:0]  cpu_mode = 5'b10011;
    logic        ns_state = 0, lock_req = 0, flush_pulse = 0;
    logic        dtcm_ns_ok = 0, itcm_ns_ok = 0;
    logic        trap, commit;
    logic [31:0] rd_data;

    int n_chk = 0, n_fail = 0;
    logic [31:0] mdl [21];
    logic        m_eff = 0, m_pend = 0;
    bit          done = 0;

    always #10 clk = ~clk;

    scg_guard dut (.*);

    // bench view of the protected list: -1 = unprotected, 6/7 = TCM regions, 20 = validation group
    function automatic int ref_slot(logic [2:0] o1, logic [3:0] n, logic [3:0] m, logic [2:0] o2);
        if (n == 15 && m == 13) return 20;
        if (o1 == 0 && n == 15 && ((m == 9 && o2 == 0) || (m == 14 && o2 == 0) || (m == 12 && o2 >= 4))) return 20;
        if (o1 == 3 && n == 15 && m == 8)  return 14;
        if (o1 == 3 && n == 15 && m == 12) return 15;
        if (o1 == 5 && n == 15 && m >= 4 && m <= 7 && o2 == 2) return 12 + int'(m);
        if (o1 != 0) return -1;
        if (n == 1 && m == 0 && o2 == 0) return 0;
        if (n == 2 && m == 0 && o2 == 0) return 1;
        if (n == 2 && m == 0 && o2 == 2) return 2;
        if (n == 3 && m == 0 && o2 == 0) return 3;
        if (n == 9 && m == 1 && o2 <= 3) return (o2 >= 2) ? int'(o2) + 2 : int'(o2) + 6;
        if (n == 10 && m == 2 && o2 <= 1) return 8 + int'(o2);
        if (n == 12 && m == 0 && o2 <= 1) return 10 + int'(o2);
        if (n == 13 && m == 0 && o2 == 0) return 12;
        if (n == 15 && m == 2 && o2 == 4) return 13;
        return -1;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive one cycle (called at negedge), check mid-cycle, update the model at the edge
    task automatic cyc(logic v, logic w, logic [2:0] o1, logic [3:0] n, logic [3:0] m,
                       logic [2:0] o2, logic [31:0] d, logic [4:0] md, logic s,
                       logic lk, logic fl, logic dok, logic iok);
        int   sl;
        logic pr, tcm, tok, et, ec;
        logic [31:0] erd;
        string tag;
        acc_valid = v; acc_write = w; acc_opc1 = o1; acc_crn = n; acc_crm = m; acc_opc2 = o2;
        acc_wdata = d; cpu_mode = md; ns_state = s; lock_req = lk; flush_pulse = fl;
        dtcm_ns_ok = dok; itcm_ns_ok = iok;
        #5;
        sl  = ref_slot(o1, n, m, o2);
        pr  = (md == 5'b10110) || (md != 5'b10000 && !s);
        tcm = (sl == 6 || sl == 7);
        tok = (sl == 6) ? dok : iok;
        et  = v && sl >= 0 && ((!tcm && !pr) || (w && m_eff && (!tcm || !tok)));
        ec  = v && !et;
        erd = (ec && !w && sl >= 0) ? mdl[sl] : 32'h0;
        if (!v)                  tag = "R8";
        else if (sl < 0)         tag = "R7";
        else if (tcm)            tag = "R5";
        else if (!pr)            tag = "R4";
        else if (w && m_eff)     tag = "R2";
        else if (!w)             tag = "R3";
        else                     tag = "R1";
        check({tag, " trap"}, {31'b0, trap}, {31'b0, et});
        check({tag, " commit"}, {31'b0, commit}, {31'b0, ec});
        check({tag, " rd_data"}, rd_data, erd);
        @(posedge clk);
        if (ec && w && sl >= 0) mdl[sl] = d;
        if (fl) m_eff = m_pend;
        m_pend = lk;
        @(negedge clk);
    endtask

    task automatic rd(logic [2:0] o1, logic [3:0] n, logic [3:0] m, logic [2:0] o2, logic lk);
        cyc(1, 0, o1, n, m, o2, 0, 5'b10110, 0, lk, 0, 0, 0);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5C6A_0017));
        for (int i = 0; i < 21; i++) mdl[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset values and unlocked write from secure privileged mode
        rd(0, 1, 0, 0, 0);
        check("R1 reset word", rd_data, 32'h0);
        cyc(1, 1, 0, 1, 0, 0, 32'hA5A5_0001, 5'b10011, 0, 0, 0, 0, 0);
        rd(0, 1, 0, 0, 0);
        check("R1 readback", rd_data, 32'hA5A5_0001);

        // R4: user mode and non-secure privileged access traps while unlocked
        cyc(1, 0, 0, 1, 0, 0, 0, 5'b10000, 0, 0, 0, 0, 0);
        check("R4 user read trap", {31'b0, trap}, 32'h1);
        cyc(1, 1, 0, 2, 0, 0, 32'h1, 5'b10011, 1, 0, 0, 0, 0);
        check("R4 ns priv write trap", {31'b0, trap}, 32'h1);
        cyc(1, 1, 0, 2, 0, 0, 32'h77, 5'b10110, 1, 0, 0, 0, 0);
        check("R4 monitor ns write commit", {31'b0, commit}, 32'h1);

        // R6: flush in the cycle the request rises does not lock
        cyc(0, 0, 0, 0, 0, 0, 0, 5'b10011, 0, 1, 1, 0, 0);
        cyc(1, 1, 0, 1, 0, 0, 32'hBEEF_0002, 5'b10011, 0, 1, 0, 0, 0);
        check("R6 early flush no lock", {31'b0, commit}, 32'h1);
        cyc(0, 0, 0, 0, 0, 0, 0, 5'b10011, 0, 1, 1, 0, 0);
        cyc(1, 1, 0, 1, 0, 0, 32'hDEAD_0003, 5'b10011, 0, 1, 0, 0, 0);
        check("R6 locked after flush", {31'b0, trap}, 32'h1);

        // R2/R3: locked write blocked, read still works and word unchanged
        rd(0, 1, 0, 0, 1);
        check("R2 word unchanged", rd_data, 32'hBEEF_0002);
        cyc(1, 1, 5, 15, 7, 2, 32'h9, 5'b10110, 0, 1, 0, 0, 0);
        check("R2 tlb attr locked", {31'b0, trap}, 32'h1);

        // R7: ordinary register unaffected by the lock, even from user mode
        cyc(1, 1, 0, 1, 0, 1, 32'h5, 5'b10000, 1, 1, 0, 0, 0);
        check("R7 unprotected commit", {31'b0, commit}, 32'h1);

        // R5: TCM region registers under lock, user non-secure mode
        cyc(1, 1, 0, 9, 1, 0, 32'h11, 5'b10000, 1, 1, 0, 0, 1);
        check("R5 dtcm locked bit0", {31'b0, trap}, 32'h1);
        cyc(1, 1, 0, 9, 1, 0, 32'h12, 5'b10000, 1, 1, 0, 1, 0);
        check("R5 dtcm open bit1", {31'b0, commit}, 32'h1);
        cyc(1, 1, 0, 9, 1, 1, 32'h13, 5'b10000, 1, 1, 0, 1, 0);
        check("R5 itcm locked bit0", {31'b0, trap}, 32'h1);
        rd(0, 9, 1, 0, 1);
        check("R5 dtcm word", rd_data, 32'h12);

        // release the lock: R6 drop then flush
        cyc(0, 0, 0, 0, 0, 0, 0, 5'b10011, 0, 0, 0, 0, 0);
        cyc(1, 1, 0, 1, 0, 0, 32'h3, 5'b10011, 0, 0, 0, 0, 0);
        check("R6 still locked w/o flush", {31'b0, trap}, 32'h1);
        cyc(0, 0, 0, 0, 0, 0, 0, 5'b10011, 0, 0, 1, 0, 0);

        // R9: aliasing of wildcard groups
        cyc(1, 1, 3, 15, 8, 1, 32'hC0DE_0014, 5'b10011, 0, 0, 0, 0, 0);
        rd(3, 15, 8, 6, 0);
        check("R9 icache mv alias", rd_data, 32'hC0DE_0014);
        cyc(1, 1, 6, 15, 13, 3, 32'hC0DE_0020, 5'b10011, 0, 0, 0, 0, 0);
        rd(0, 15, 12, 5, 0);
        check("R9 validation alias", rd_data, 32'hC0DE_0020);

        // R8: idle cycle with write fields leaves word intact
        cyc(0, 1, 0, 1, 0, 0, 32'hFFFF_FFFF, 5'b10110, 0, 0, 0, 0, 0);
        rd(0, 1, 0, 0, 0);
        check("R8 idle no write", rd_data, 32'hBEEF_0002);

        // constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] o1, o2; logic [3:0] n, m; logic [4:0] md;
            int k;
            k  = $urandom_range(0, 29);
            o1 = 3'($urandom); o2 = 3'($urandom); n = 4'($urandom); m = 4'($urandom);
            case (k)
                0: begin o1 = 0; n = 1;  m = 0;  o2 = 0; end
                1: begin o1 = 0; n = 2;  m = 0;  o2 = 0; end
                2: begin o1 = 0; n = 2;  m = 0;  o2 = 2; end
                3: begin o1 = 0; n = 3;  m = 0;  o2 = 0; end
                4: begin o1 = 0; n = 9;  m = 1;  o2 = 3'($urandom_range(0, 3)); end
                5: begin o1 = 0; n = 10; m = 2;  o2 = 3'($urandom_range(0, 1)); end
                6: begin o1 = 0; n = 12; m = 0;  o2 = 3'($urandom_range(0, 1)); end
                7: begin o1 = 0; n = 13; m = 0;  o2 = 0; end
                8: begin o1 = 0; n = 15; m = 2;  o2 = 4; end
                9: begin o1 = 3; n = 15; m = 8; end
                10: begin o1 = 3; n = 15; m = 12; end
                11: begin o1 = 5; n = 15; m = 4'($urandom_range(4, 7)); o2 = 2; end
                12: begin o1 = 0; n = 15; m = 9;  o2 = 0; end
                13: begin o1 = 0; n = 15; m = 12; o2 = 3'($urandom_range(4, 7)); end
                14: begin o1 = 0; n = 15; m = 14; o2 = 0; end
                15: begin n = 15; m = 13; end
                16: begin o1 = 0; n = 9; m = 1; o2 = 3'($urandom_range(0, 1)); end
                default: ;
            endcase
            case ($urandom_range(0, 4))
                0: md = 5'b10000; 1: md = 5'b10011; 2: md = 5'b10110;
                3: md = 5'b11111; default: md = 5'b10001;
            endcase
            cyc($urandom_range(0, 9) != 0, 1'($urandom), o1, n, m, o2, $urandom, md,
                $urandom_range(0, 3) == 0,
                ($urandom_range(0, 15) == 0) ? ~lock_req : lock_req,
                $urandom_range(0, 9) == 0, 1'($urandom), 1'($urandom));
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule